// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides which exception a small CPU takes next and then performs the memory steps needed to enter it. It has three sources. The first is a reset, which comes either from the external reset line going high again after being held low or from a watchdog overflow pulse. The second is an interrupt request from the interrupt controller, which may be maskable or non-maskable. The third is a trap strobe that the instruction decoder raises when a trap instruction executes. Reset always wins. An interrupt beats a trap that arrives in the same cycle. A trap that cannot be taken at once is held and taken later.

An accepted interrupt or trap pushes the current program counter and then the control register onto a descending stack. After that it signals the mask update, hands the new stack pointer back to the CPU, reads the handler address from the vector table and loads it as the new program counter. A reset entry only reads vector 0 and loads it. Memory is reached through a simple request/acknowledge bus. After any reset, no interrupt is accepted, not even a non-maskable one, until software re-arms the block by writing the stack pointer or a control register.

Top module: `exc_entry_seq`

## Requirements
- R1: After `rst`, the outputs `busy`, `mem_req`, `pc_load`, `mask_set` and `sp_load` are low, and interrupts are disarmed.
- R2: Reset has priority over interrupt, and interrupt over trap. When an interrupt and a trap are both acceptable in the same cycle, the interrupt entry runs first and the trap entry follows without a new strobe. A reset event in the same cycle as an interrupt request produces only a reset entry.
- R3: While `ext_rst_n` is low, `busy` is high and the bus is idle. A reset entry starts on the first cycle `ext_rst_n` is sampled high after being low, or on a `wdt_ovf` pulse. A reset entry performs one read at address `VEC_BASE` (exception 0), then `pc_load` with the read data. It performs no writes and pulses neither `mask_set` nor `sp_load`. A reset event aborts any entry in progress.
- R4: An interrupt is accepted only in two places. The first is a cycle with `insn_end`=1 and `insn_blk`=0. The second is the first idle cycle after a non-reset entry has loaded the program counter. A maskable request (`irq_nmi`=0) also needs `irq_mask`=0. A non-maskable request ignores `irq_mask`.
- R5: After any reset (`rst`, external line or watchdog), no interrupt is accepted, not even one with `irq_nmi`=1, until `sw_arm` has been pulsed.
- R6: A `trap_exec` pulse in an idle cycle is accepted whatever the values of `irq_mask` and `insn_blk`. A trap pulse that arrives while `busy` is high, or that loses to an interrupt, is held and entered once the block is idle.
- R7: For an interrupt or trap entry with stack pointer S and exception number N, the bus steps come in this order. First, write the PC at S-2. Second, write the control register at S-4. Third, pulse `mask_set` and `sp_load` with `sp_val`=S-4. Fourth, read address `VEC_BASE`+N*`VEC_BYTES`. Fifth, pulse `pc_load` with the read data on `pc_val`.
- R8: `busy` rises in the cycle after acceptance and stays high through the `pc_load` cycle. `busy` is low in the cycle after `pc_load`, unless a reset event occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| ext_rst_n | input | 1 | External reset line, active low |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_req | input | 1 | Interrupt request pending (level) |
| irq_nmi | input | 1 | Pending request is non-maskable |
| irq_mask | input | 1 | Maskable interrupts blocked when 1 |
| irq_num | input | NUM_W | Exception number of the request |
| trap_exec | input | 1 | Trap instruction executed (pulse) |
| trap_num | input | NUM_W | Exception number of the trap |
| insn_end | input | 1 | Current instruction completes this cycle |
| insn_blk | input | 1 | Completing instruction blocks interrupts |
| sw_arm | input | 1 | Software wrote SP or a control register |
| cur_pc | input | AW | Program counter to save |
| cur_sp | input | AW | Stack pointer at entry |
| cur_ccr | input | DW | Control register to save |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write when 1 |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | DW | Bus write data |
| mem_ack | input | 1 | Bus acknowledge; step completes |
| mem_rdata | input | DW | Bus read data, valid with ack |
| busy | output | 1 | Entry sequence or reset hold active |
| mask_set | output | 1 | Raise the interrupt mask bits (pulse) |
| sp_load | output | 1 | Load `sp_val` into the stack pointer (pulse) |
| sp_val | output | AW | Stack pointer after the pushes |
| pc_load | output | 1 | Load `pc_val` into the PC (pulse) |
| pc_val | output | AW | Handler address |

## Verification
The bench models the bus with one wait state, so every access takes two cycles. Counting from the edge that accepts an interrupt or trap, `mask_set` is due in the 5th cycle and `pc_load` in the 8th. A reset entry loads the PC in the 3rd cycle after the release or watchdog edge. A chained entry loads its PC 9 cycles after the previous `pc_load`. Each check counts falling edges from the one where the stimulus was applied and samples the outputs at exactly the expected one. The bus writes, the stack pointer value and the read address are captured at the acknowledging edge and compared after the sequence ends.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_PUSH_PC, ST_PUSH_CCR, ST_MASK, ST_FETCH, ST_LOAD
  } seq_state_t;

  typedef enum logic [1:0] {
    K_RST, K_IRQ, K_TRAP
  } exc_kind_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int NUM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic             rst_evt,
  input  logic             seq_done,
  input  logic             insn_end,
  input  logic             insn_blk,
  input  logic             irq_req,
  input  logic             irq_nmi,
  input  logic             irq_mask,
  input  logic [NUM_W-1:0] irq_num,
  input  logic             trap_exec,
  input  logic [NUM_W-1:0] trap_num,
  input  logic             sw_arm,
  output logic             take_irq,
  output logic             take_trap,
  output logic [NUM_W-1:0] take_num
);
  logic             arm_q;
  logic             trap_pend_q;
  logic [NUM_W-1:0] trap_num_q;
  logic             done_q;
  logic             irq_ok;
  logic             point;

  // acceptance points: clean instruction end, or first idle cycle after an entry
  assign irq_ok    = irq_req && arm_q && (irq_nmi || !irq_mask);
  assign point     = (insn_end && !insn_blk) || done_q;
  assign take_irq  = idle && !rst_evt && point && irq_ok;
  assign take_trap = idle && !rst_evt && !take_irq && (trap_exec || trap_pend_q);
  assign take_num  = take_irq ? irq_num : (trap_pend_q ? trap_num_q : trap_num);

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q       <= 1'b0;
      trap_pend_q <= 1'b0;
      trap_num_q  <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= seq_done && !rst_evt;
      if (rst_evt)     arm_q <= 1'b0;
      else if (sw_arm) arm_q <= 1'b1;
      if (rst_evt) begin
        trap_pend_q <= 1'b0;
      end else if (trap_exec && !(take_trap && !trap_pend_q)) begin
        trap_pend_q <= 1'b1;
        trap_num_q  <= trap_num;
      end else if (take_trap) begin
        trap_pend_q <= 1'b0;
      end
    end
  end

  // R5: arming only ever follows a software write strobe
  p_arm_source_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(arm_q) |-> $past(sw_arm));
endmodule

// File: rtl/exc_seq_fsm.sv
module exc_seq_fsm
  import exc_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter int          NUM_W     = 6,
  parameter logic [AW-1:0] VEC_BASE = '0,
  parameter int          VEC_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             rst_start,
  input  logic             take_irq,
  input  logic             take_trap,
  input  logic [NUM_W-1:0] take_num,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    cur_sp,
  input  logic [DW-1:0]    cur_ccr,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             idle,
  output logic             seq_done,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             mask_set,
  output logic             sp_load,
  output logic [AW-1:0]    sp_val,
  output logic             pc_load,
  output logic [AW-1:0]    pc_val
);
  localparam int WORD_BYTES = DW / 8;

  seq_state_t       state;
  exc_kind_t        kind;
  logic [NUM_W-1:0] num_r;
  logic [AW-1:0]    pc_r, sp_r, vec_r;
  logic [DW-1:0]    ccr_r;
  logic [AW-1:0]    push_addr, vec_addr;

  assign push_addr = sp_r - AW'(WORD_BYTES);
  assign vec_addr  = VEC_BASE + (AW'(num_r) * AW'(VEC_BYTES));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      kind  <= K_RST;
      num_r <= '0;
      pc_r  <= '0;
      sp_r  <= '0;
      ccr_r <= '0;
      vec_r <= '0;
    end else if (hold) begin
      state <= ST_HOLD;
    end else if (rst_start) begin
      state <= ST_FETCH;
      kind  <= K_RST;
      num_r <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (take_irq || take_trap) begin
          state <= ST_PUSH_PC;
          kind  <= take_irq ? K_IRQ : K_TRAP;
          num_r <= take_num;
          pc_r  <= cur_pc;
          sp_r  <= cur_sp;
          ccr_r <= cur_ccr;
        end
        ST_HOLD: state <= ST_HOLD;
        ST_PUSH_PC: if (mem_ack) begin
          sp_r  <= push_addr;
          state <= ST_PUSH_CCR;
        end
        ST_PUSH_CCR: if (mem_ack) begin
          sp_r  <= push_addr;
          state <= ST_MASK;
        end
        ST_MASK: state <= ST_FETCH;
        ST_FETCH: if (mem_ack) begin
          vec_r <= AW'(mem_rdata);
          state <= ST_LOAD;
        end
        ST_LOAD: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state == ST_PUSH_PC) || (state == ST_PUSH_CCR) || (state == ST_FETCH);
  assign mem_we    = (state == ST_PUSH_PC) || (state == ST_PUSH_CCR);
  assign mem_addr  = (state == ST_FETCH) ? vec_addr : push_addr;
  assign mem_wdata = (state == ST_PUSH_PC) ? DW'(pc_r) : ccr_r;
  assign mask_set  = (state == ST_MASK);
  assign sp_load   = (state == ST_MASK);
  assign sp_val    = sp_r;
  assign pc_load   = (state == ST_LOAD);
  assign pc_val    = vec_r;
  assign seq_done  = (state == ST_LOAD) && (kind != K_RST);

  // R3: a reset entry never writes to memory
  p_reset_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (kind != K_RST));
  // R8: busy drops right after the PC is loaded
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !hold && !rst_start) |=> !busy);
  // R7: the mask update is followed by the vector read
  p_mask_then_fetch_r7: assert property (@(posedge clk) disable iff (rst)
    (mask_set && !hold && !rst_start) |=> (mem_req && !mem_we));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq #(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter int            NUM_W     = 6,
  parameter logic [AW-1:0] VEC_BASE  = '0,
  parameter int            VEC_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_rst_n,
  input  logic             wdt_ovf,
  input  logic             irq_req,
  input  logic             irq_nmi,
  input  logic             irq_mask,
  input  logic [NUM_W-1:0] irq_num,
  input  logic             trap_exec,
  input  logic [NUM_W-1:0] trap_num,
  input  logic             insn_end,
  input  logic             insn_blk,
  input  logic             sw_arm,
  input  logic [AW-1:0]    cur_pc,
  input  logic [AW-1:0]    cur_sp,
  input  logic [DW-1:0]    cur_ccr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             mask_set,
  output logic             sp_load,
  output logic [AW-1:0]    sp_val,
  output logic             pc_load,
  output logic [AW-1:0]    pc_val
);
  logic             pin_q;
  logic             hold, rst_start, rst_evt;
  logic             idle, seq_done, take_irq, take_trap;
  logic [NUM_W-1:0] take_num;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b1;
    else     pin_q <= ext_rst_n;
  end

  assign hold      = !ext_rst_n;
  assign rst_start = (ext_rst_n && !pin_q) || wdt_ovf;
  assign rst_evt   = hold || rst_start;

  exc_arbiter #(.NUM_W(NUM_W)) u_arb (
    .clk(clk), .rst(rst), .idle(idle), .rst_evt(rst_evt), .seq_done(seq_done),
    .insn_end(insn_end), .insn_blk(insn_blk), .irq_req(irq_req),
    .irq_nmi(irq_nmi), .irq_mask(irq_mask), .irq_num(irq_num),
    .trap_exec(trap_exec), .trap_num(trap_num), .sw_arm(sw_arm),
    .take_irq(take_irq), .take_trap(take_trap), .take_num(take_num)
  );

  exc_seq_fsm #(
    .AW(AW), .DW(DW), .NUM_W(NUM_W), .VEC_BASE(VEC_BASE), .VEC_BYTES(VEC_BYTES)
  ) u_fsm (
    .clk(clk), .rst(rst), .hold(hold), .rst_start(rst_start),
    .take_irq(take_irq), .take_trap(take_trap), .take_num(take_num),
    .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_ccr(cur_ccr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .idle(idle), .seq_done(seq_done), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mask_set(mask_set), .sp_load(sp_load), .sp_val(sp_val),
    .pc_load(pc_load), .pc_val(pc_val)
  );

  // R3: a low reset line parks the block with the bus quiet
  p_hold_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !ext_rst_n |=> (busy && !mem_req));
endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_rst_n = 1'b1, wdt_ovf = 1'b0;
  logic        irq_req = 1'b0, irq_nmi = 1'b0, irq_mask = 1'b0;
  logic [5:0]  irq_num = '0, trap_num = '0;
  logic        trap_exec = 1'b0, insn_end = 1'b0, insn_blk = 1'b0, sw_arm = 1'b0;
  logic [15:0] cur_pc = '0, cur_sp = 16'h2000, cur_ccr = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, mask_set, sp_load, pc_load;
  logic [15:0] sp_val, pc_val;

  int total = 0, bad = 0;
  int wn = 0, mk_n = 0, rd_n = 0;
  logic [15:0] w_prev_a, w_prev_d, w_last_a, w_last_d, rd_a, spv;

  // src 0 = maskable irq, 1 = nmi, 2 = trap; fields {src, num, mask, blk, expect_take}
  localparam logic [10:0] TBL [8] = '{
    {2'd0, 6'd12, 1'b0, 1'b0, 1'b1},
    {2'd0, 6'd20, 1'b1, 1'b0, 1'b0},
    {2'd1, 6'd7,  1'b1, 1'b0, 1'b1},
    {2'd0, 6'd30, 1'b0, 1'b1, 1'b0},
    {2'd2, 6'd8,  1'b1, 1'b0, 1'b1},
    {2'd1, 6'd7,  1'b0, 1'b1, 1'b0},
    {2'd2, 6'd9,  1'b0, 1'b1, 1'b1},
    {2'd0, 6'd63, 1'b0, 1'b0, 1'b1}
  };

  always #5 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .wdt_ovf(wdt_ovf),
    .irq_req(irq_req), .irq_nmi(irq_nmi), .irq_mask(irq_mask), .irq_num(irq_num),
    .trap_exec(trap_exec), .trap_num(trap_num), .insn_end(insn_end),
    .insn_blk(insn_blk), .sw_arm(sw_arm), .cur_pc(cur_pc), .cur_sp(cur_sp),
    .cur_ccr(cur_ccr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .mask_set(mask_set), .sp_load(sp_load), .sp_val(sp_val),
    .pc_load(pc_load), .pc_val(pc_val)
  );

  // bus model: one wait state, vector data = 0x4000 + address
  assign mem_rdata = 16'h4000 + mem_addr;
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else     mem_ack <= mem_req && !mem_ack;
  end

  always @(posedge clk) begin
    if (!rst && mem_req && mem_ack) begin
      if (mem_we) begin
        w_prev_a <= w_last_a; w_prev_d <= w_last_d;
        w_last_a <= mem_addr; w_last_d <= mem_wdata;
        wn <= wn + 1;
      end else begin
        rd_a <= mem_addr;
        rd_n <= rd_n + 1;
      end
    end
    if (!rst && mask_set) mk_n <= mk_n + 1;
    if (!rst && sp_load)  spv <= sp_val;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_pc(output logic [15:0] v, output int c);
    v = '0; c = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (pc_load) begin v = pc_val; c = k; break; end
    end
  endtask

  task automatic arm();
    @(negedge clk); sw_arm = 1'b1;
    @(negedge clk); sw_arm = 1'b0;
  endtask

  task automatic do_seq(input logic [1:0] src, input logic [5:0] num, input logic msk,
                        input logic blk, input logic take, input string tag);
    int wn0, mk0, seen;
    logic [15:0] pc_e, ccr_e, va;
    while (busy) @(negedge clk);
    @(negedge clk);
    pc_e = 16'h0400 + {10'd0, num};
    ccr_e = 16'h00A0 + {10'd0, num};
    va = {9'd0, num, 1'b0};
    cur_pc = pc_e; cur_sp = 16'h2000; cur_ccr = ccr_e;
    irq_mask = msk; insn_blk = blk; irq_num = num; trap_num = num;
    if (src == 2'd2) trap_exec = 1'b1;
    else begin irq_req = 1'b1; irq_nmi = (src == 2'd1); insn_end = 1'b1; end
    wn0 = wn; mk0 = mk_n;
    @(negedge clk);
    trap_exec = 1'b0; irq_req = 1'b0; insn_end = 1'b0; irq_nmi = 1'b0; insn_blk = 1'b0;
    chk({tag, " R8 busy after accept"}, busy, take);
    seen = 0;
    for (int k = 1; k <= 12; k++) begin
      if (pc_load) begin seen = k; break; end
      @(negedge clk);
    end
    if (take) begin
      chk({tag, " R8 pc_load cycle"}, seen, 8);
      chk({tag, " R7 pc_val"}, pc_val, 16'h4000 + va);
      chk({tag, " R7 pc push addr"}, w_prev_a, 16'h1FFE);
      chk({tag, " R7 pc push data"}, w_prev_d, pc_e);
      chk({tag, " R7 ccr push addr"}, w_last_a, 16'h1FFC);
      chk({tag, " R7 ccr push data"}, w_last_d, ccr_e);
      chk({tag, " R7 sp_val"}, spv, 16'h1FFC);
      chk({tag, " R7 mask_set count"}, mk_n - mk0, 1);
      chk({tag, " R7 vector addr"}, rd_a, va);
    end else begin
      chk({tag, " R4 not taken"}, seen, 0);
      chk({tag, " R4 no writes"}, wn - wn0, 0);
    end
  endtask

  initial begin
    logic [15:0] v;
    int c, wn0, mk0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 pc_load", pc_load, 0);
    chk("R1 mask_set/sp_load", {mask_set, sp_load}, 0);
    // R1 / R5 disarmed after block reset: nmi refused
    do_seq(2'd1, 6'd5, 1'b0, 1'b0, 1'b0, "R5 nmi before arm");
    arm();

    for (int i = 0; i < 8; i++)
      do_seq(TBL[i][10:9], TBL[i][8:3], TBL[i][2], TBL[i][1], TBL[i][0], "R4/R6 table");

    // R2 interrupt and trap together: interrupt first, trap follows
    while (busy) @(negedge clk);
    @(negedge clk);
    irq_req = 1'b1; insn_end = 1'b1; irq_num = 6'd3; irq_mask = 1'b0;
    trap_exec = 1'b1; trap_num = 6'd11;
    @(negedge clk);
    irq_req = 1'b0; insn_end = 1'b0; trap_exec = 1'b0;
    wait_pc(v, c);
    chk("R2 first is irq", v, 16'h4006);
    chk("R2 first latency", c, 7);
    wait_pc(v, c);
    chk("R2 trap follows", v, 16'h4016);
    chk("R6 held trap latency", c, 9);

    // R6 trap during busy is held
    while (busy) @(negedge clk);
    @(negedge clk);
    irq_req = 1'b1; insn_end = 1'b1; irq_num = 6'd2;
    @(negedge clk);
    irq_req = 1'b0; insn_end = 1'b0;
    @(negedge clk);
    trap_exec = 1'b1; trap_num = 6'd13;
    @(negedge clk);
    trap_exec = 1'b0;
    wait_pc(v, c);
    chk("R6 irq before held trap", v, 16'h4004);
    wait_pc(v, c);
    chk("R6 held trap entered", v, 16'h401A);

    // R4 interrupt accepted at end of exception sequence
    while (busy) @(negedge clk);
    @(negedge clk);
    trap_exec = 1'b1; trap_num = 6'd5;
    @(negedge clk);
    trap_exec = 1'b0;
    @(negedge clk);
    irq_req = 1'b1; irq_num = 6'd14; irq_mask = 1'b0;
    wait_pc(v, c);
    chk("R4 trap entry first", v, 16'h400A);
    @(negedge clk); @(negedge clk);
    irq_req = 1'b0;
    wait_pc(v, c);
    chk("R4 irq at sequence end", v, 16'h401C);
    chk("R4 chained latency", c, 7);

    // R3 external reset line
    while (busy) @(negedge clk);
    @(negedge clk);
    ext_rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R3 hold busy", busy, 1);
      chk("R3 hold bus idle", mem_req, 0);
    end
    wn0 = wn; mk0 = mk_n;
    ext_rst_n = 1'b1;
    wait_pc(v, c);
    chk("R3 reset vector", v, 16'h4000);
    chk("R3 reset latency", c, 3);
    chk("R3 reset read addr", rd_a, 16'h0000);
    chk("R3 reset no writes", wn - wn0, 0);
    chk("R3 reset no mask_set", mk_n - mk0, 0);
    do_seq(2'd1, 6'd7, 1'b0, 1'b0, 1'b0, "R5 nmi after line reset");
    arm();

    // R3 watchdog aborts an interrupt entry
    while (busy) @(negedge clk);
    @(negedge clk);
    irq_req = 1'b1; insn_end = 1'b1; irq_num = 6'd4;
    mk0 = mk_n;
    @(negedge clk);
    irq_req = 1'b0; insn_end = 1'b0;
    @(negedge clk); @(negedge clk);
    wdt_ovf = 1'b1;
    @(negedge clk);
    wdt_ovf = 1'b0;
    wait_pc(v, c);
    chk("R3 abort to reset vector", v, 16'h4000);
    chk("R3 abort no mask_set", mk_n - mk0, 0);
    do_seq(2'd1, 6'd7, 1'b0, 1'b0, 1'b0, "R5 nmi after watchdog");
    arm();

    // R2 watchdog beats a simultaneous interrupt
    while (busy) @(negedge clk);
    @(negedge clk);
    wdt_ovf = 1'b1; irq_req = 1'b1; insn_end = 1'b1; irq_num = 6'd6;
    wn0 = wn;
    @(negedge clk);
    wdt_ovf = 1'b0; irq_req = 1'b0; insn_end = 1'b0;
    wait_pc(v, c);
    chk("R2 reset wins", v, 16'h4000);
    chk("R2 reset latency", c, 2);
    chk("R2 no pushes", wn - wn0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule